// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction-Selected Read-Back

This block is an eight-pin general-purpose I/O port attached to a simple synchronous register bus. Software sees three registers. An output latch holds the value that output pins drive. A direction register makes each pin an output (bit = 1) or an input (bit = 0). A pull-up register asks for the internal pull-up on pins that are inputs. Toward the pads, the block produces an output enable, an output value and a pull-up request for each pin, and it takes in the raw pad levels.

A read of the data register is assembled bit by bit. Output pins return their latch bit. Input pins return the pad level after it has passed through a two-flop synchroniser. The latch can be written at any time. On an input pin the latch value stays hidden from the pad until the pin becomes an output. The pull-up request is raised only for a pin that is an input and has its pull-up bit set.

The bus write is a single cycle: `bus_we` with `bus_addr` and `bus_wdata`. Read data is combinational from `bus_addr`. Reset is synchronous and active high.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and after it is released, the output latch, the direction register and the pull-up register are all 0x00, so `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R2: A write to address 0x3 loads `bus_wdata` into the output latch whatever the direction bits are. `pad_out` bit i equals latch bit i AND direction bit i, so a latch bit on an input pin never reaches the pad.
- R3: A read of address 0x3 returns, for each bit i, latch bit i when direction bit i is 1 and the synchronised pad level of pin i when direction bit i is 0.
- R4: A change on `pad_in` shows up in data-register read data after the second rising clock edge that follows it, and not after the first.
- R5: Address 0x7 holds the direction register. All eight bits can be written with any value and read back unchanged, and `pad_oe` equals the direction register.
- R6: Address 0xC holds the pull-up register. It is fully readable and writable, and `pad_pu` bit i equals pull-up bit i AND NOT direction bit i.
- R7: Every read of an address other than 0x3, 0x7 and 0xC returns 0x00. A write to any such address leaves all three registers unchanged.
- R8: The pad controls keep their old values until the rising edge that takes a register write, and they carry the new values from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Raw pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up request |

## Verification
The bench sweeps every direction value and mixes latch, direction and pad patterns, so that a read mux that picks its source for the whole word rather than bit by bit returns wrong bits. It writes the latch while pins are inputs, which exposes a design that drops such writes or leaks the latch to `pad_out`. It times pad changes against one and two clock edges to catch a synchroniser with a stage too many or too few. It also sweeps direction against pull-up settings, which catches a pull-up that is not gated by the direction bit, and writes 0xFF to every unmapped address to catch decode aliasing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 4'h7;
    localparam logic [ADDR_W-1:0] ADDR_PULL = 4'hC;

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PULL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        port_vec_t latch;
        port_vec_t dir;
        port_vec_t pull;
    } port_regs_t;

    typedef struct packed {
        port_vec_t oe;
        port_vec_t out;
        port_vec_t pu;
    } pad_ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_DATA: return SEL_DATA;
            ADDR_DIR:  return SEL_DIR;
            ADDR_PULL: return SEL_PULL;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Picks, for each bit, the latch on an output pin or the pad level on an input pin.
    function automatic port_vec_t mux_readback(input port_vec_t dir,
                                               input port_vec_t latch,
                                               input port_vec_t pin);
        port_vec_t r;
        for (int i = 0; i < PORT_W; i++) begin
            r[i] = dir[i] ? latch[i] : pin[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  port_vec_t         wr_data,
    output port_regs_t        regs
);

    reg_sel_e   wsel;
    port_regs_t regs_q;

    assign wsel = decode_addr(wr_addr);
    assign regs = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                SEL_DATA: regs_q.latch <= wr_data;
                SEL_DIR:  regs_q.dir   <= wr_data;
                SEL_PULL: regs_q.pull  <= wr_data;
                default:  ;
            endcase
        end
    end

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == SEL_NONE) |=> $stable(regs_q));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DATA) |=> (regs_q.latch == $past(wr_data)));

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DIR) |=> (regs_q.dir == $past(wr_data)));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
    import gpio_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  port_vec_t pin_raw,
    output port_vec_t pin_sync
);

    port_vec_t stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];

    // Counts the edges since reset, so that the latency check never looks past them.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R4
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (pin_sync == $past(pin_raw, 2)));

endmodule

// File: rtl/gpio_port_padctl.sv
module gpio_port_padctl
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_regs_t regs,
    output pad_ctrl_t  pad
);

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            assign pad.oe[i]  = regs.dir[i];
            assign pad.out[i] = regs.dir[i] & regs.latch[i];
            assign pad.pu[i]  = regs.pull[i] & ~regs.dir[i];
        end
    endgenerate

    // R6
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad.pu & pad.oe) == '0);

    // R2
    out_only_when_driven_chk: assert property (@(posedge clk) disable iff (rst)
        (pad.out & ~pad.oe) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);

    port_regs_t regs;
    port_vec_t  pin_sync;
    pad_ctrl_t  pad;

    gpio_port_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (bus_addr),
        .wr_en   (bus_we),
        .wr_data (bus_wdata),
        .regs    (regs)
    );

    gpio_port_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_port_padctl u_padctl (
        .clk  (clk),
        .rst  (rst),
        .regs (regs),
        .pad  (pad)
    );

    always_comb begin
        case (decode_addr(bus_addr))
            SEL_DATA: bus_rdata = mux_readback(regs.dir, regs.latch, pin_sync);
            SEL_DIR:  bus_rdata = regs.dir;
            SEL_PULL: bus_rdata = regs.pull;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_oe  = pad.oe;
    assign pad_out = pad.out;
    assign pad_pu  = pad.pu;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_DATA && bus_addr != ADDR_DIR && bus_addr != ADDR_PULL)
            |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drives at the falling edge, lets one rising edge take the write, returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] l, d, p, u;

        @(negedge clk);
        tick(3);
        // R1: state while reset is held
        check("R1 oe in reset", pad_oe, 8'h00);
        check("R1 pu in reset", pad_pu, 8'h00);
        rst = 1'b0;
        tick(1);
        rd(4'h7, v); check("R1 dir after reset", v, 8'h00);
        rd(4'hC, v); check("R1 pull after reset", v, 8'h00);
        rd(4'h3, v); check("R1 data after reset", v, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);

        // R5: every direction value reads back and drives pad_oe
        for (int i = 0; i < 256; i++) begin
            wr(4'h7, 8'(i));
            rd(4'h7, v);
            check("R5 dir readback", v, 8'(i));
            check("R5 pad_oe", pad_oe, 8'(i));
        end

        // R6: pull-up register and direction gating
        for (int i = 0; i < 256; i++) begin
            d = 8'(i);
            u = 8'(i * 37 + 11);
            wr(4'h7, d);
            wr(4'hC, u);
            rd(4'hC, v);
            check("R6 pull readback", v, u);
            check("R6 pad_pu", pad_pu, u & ~d);
        end

        // R2/R3: the latch is written while all pins are inputs and stays hidden from the pad
        wr(4'h7, 8'h00);
        pad_in = 8'h3C;
        wr(4'h3, 8'hA5);
        tick(2);
        check("R2 pad_out hidden on inputs", pad_out, 8'h00);
        rd(4'h3, v); check("R3 all-input read gives pins", v, 8'h3C);
        wr(4'h7, 8'hFF);
        check("R2 latch kept from input-time write", pad_out, 8'hA5);
        rd(4'h3, v); check("R3 all-output read gives latch", v, 8'hA5);

        // R2/R3: mixed per-bit patterns
        for (int i = 0; i < 64; i++) begin
            l = 8'(i * 73 + 5);
            d = 8'(i * 29 + 3);
            p = 8'(i * 151 + 90);
            pad_in = p;
            wr(4'h3, l);
            wr(4'h7, d);
            tick(2);
            rd(4'h3, v);
            check("R3 per-bit readback", v, (d & l) | (~d & p));
            check("R2 pad_out", pad_out, d & l);
        end

        // R4: two-edge synchroniser latency
        wr(4'h7, 8'h00);
        pad_in = 8'h00;
        tick(3);
        pad_in = 8'hC3;
        tick(1);
        rd(4'h3, v); check("R4 after one edge still old", v, 8'h00);
        tick(1);
        rd(4'h3, v); check("R4 after two edges new", v, 8'hC3);

        // R7: unmapped addresses
        wr(4'h3, 8'h5A);
        wr(4'h7, 8'h0F);
        wr(4'hC, 8'hF0);
        for (int a = 0; a < 16; a++) begin
            if (a != 3 && a != 7 && a != 12) begin
                wr(4'(a), 8'hFF);
                rd(4'(a), v);
                check("R7 unmapped read", v, 8'h00);
            end
        end
        rd(4'h7, v); check("R7 dir untouched", v, 8'h0F);
        rd(4'hC, v); check("R7 pull untouched", v, 8'hF0);
        check("R7 latch untouched", pad_out, 8'h0A);

        // R8: pad controls change only at the edge that takes the write
        bus_addr = 4'h7; bus_wdata = 8'hF0; bus_we = 1'b1;
        #1;
        check("R8 oe before edge", pad_oe, 8'h0F);
        check("R8 pu before edge", pad_pu, 8'hF0);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        check("R8 oe after edge", pad_oe, 8'hF0);
        check("R8 pu after edge", pad_pu, 8'h00);
        @(negedge clk);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule